// File: doc/BRIEF.md
# Debug Register Bank

This block is the register bank that sits between a debug transport and the run-control logic of a single hart. A transport issues requests carrying an address, an operation code and a 32-bit word. The bank answers each read or write one cycle later. It keeps the run-control register, whose 32 bits map one to one onto named control fields. It builds a status word from the hart's halted and resuming indications, and it raises a one-cycle trigger when software writes the command address.

The stored halt and resume request bits drive the hart handshake outputs directly, provided hart 0 is selected. The resume request withdraws itself when the hart reports that it is resuming, and at that moment the status word records the acknowledge. Clearing the active bit holds every other control field at zero.

Top module: `dbg_regbank`

## Requirements
- R1: Operation code 1 is a read and 2 is a write; codes 0 and 3 get no response. A read or write produces `rsp_valid_o` high for exactly one cycle, in the cycle after the request. A read returns the register value as it was before any write in that request. A write response carries zero data. A read of any address other than 0x10 (control) or 0x11 (status) returns zero.
- R2: Control register fields read back at fixed positions: halt request 31, resume request 30, hart reset 29, reset acknowledge 28, hart array select 26, select low 25:16, select high 15:6, set-reset-halt 3, clear-reset-halt 2, system reset 1, active 0. Bits 27, 5 and 4 always read as zero, so a write of all ones reads back 0xF7FFFFCF.
- R3: A control write with bit 0 clear stores zero in every field and clears the resume acknowledge. While the active bit is 0, the stored fields stay zero.
- R4: `halt_req_o` equals stored bit 31 while the hart select (high:low) is zero, and it is low otherwise. It changes in the cycle after the write.
- R5: `resume_req_o` equals stored bit 30 under the same select rule, with the same timing.
- R6: While the stored resume request is set, a high `hart_resuming_i` clears it at the next edge and sets status bits 17 and 16 (all/any resume acknowledge). A control write that sets bit 30 clears the acknowledge. A control write in the same cycle as `hart_resuming_i` takes precedence.
- R7: In the status word, bits 9 and 8 (all/any halted) equal `hart_halted_i` at the time of the request. Bits 11 and 10 (all/any running) are its inverse. Bit 7 (authenticated) is 1, bits 3:0 hold version 2, and all other bits are zero apart from R6's bits.
- R8: A write to address 0x17 while the active bit is set raises `cmd_valid_o` for one cycle, in the next cycle, with `cmd_word_o` equal to the write data. While the bank is inactive, such a write raises nothing.
- R9: After reset, every output is low and the control register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dmi_req_valid_i | input | 1 | Request present |
| dmi_req_addr_i | input | 7 | Register address |
| dmi_req_op_i | input | 2 | Operation: 1 read, 2 write |
| dmi_req_data_i | input | 32 | Write data |
| dmi_rsp_valid_o | output | 1 | Response present |
| dmi_rsp_data_o | output | 32 | Read data |
| hart_halted_i | input | 1 | Hart reports halted |
| hart_resuming_i | input | 1 | Hart reports resuming |
| halt_req_o | output | 1 | Halt request to the hart |
| resume_req_o | output | 1 | Resume request to the hart |
| cmd_valid_o | output | 1 | Command trigger pulse |
| cmd_word_o | output | 32 | Command word written |

## Verification
The hardest case to reach is the collision between a control write and the hart's resuming indication in the same cycle. The bench first leaves a resume request pending. It then raises the resuming input in exactly the cycle in which it issues a new control write, so the write's precedence shows in both the resume output and the acknowledge bits. The bench also reaches the inactive-bank cases by writing the control word with bit 0 clear just before a command write. A behavioural model compares every output on every cycle.

// File: rtl/dbg_regbank_pkg.sv
package dbg_regbank_pkg;

    localparam int DW     = 32;
    localparam int AW     = 7;
    localparam int SEL_W  = 10;

    localparam logic [AW-1:0] CTL_ADDR = 7'h10;
    localparam logic [AW-1:0] STS_ADDR = 7'h11;
    localparam logic [AW-1:0] CMD_ADDR = 7'h17;

    localparam logic [1:0] OP_READ  = 2'd1;
    localparam logic [1:0] OP_WRITE = 2'd2;

    // writable bits of the control word; 27, 5 and 4 are fixed zero
    localparam logic [DW-1:0] CTL_MASK = 32'hF7FF_FFCF;

    typedef struct packed {
        logic             halt_rq;       // 31
        logic             resume_rq;     // 30
        logic             hart_rst;      // 29
        logic             ack_rst;       // 28
        logic             rsv_a;         // 27
        logic             arr_sel;       // 26
        logic [SEL_W-1:0] sel_lo;        // 25:16
        logic [SEL_W-1:0] sel_hi;        // 15:6
        logic [1:0]       rsv_b;         // 5:4
        logic             set_rst_halt;  // 3
        logic             clr_rst_halt;  // 2
        logic             sys_rst;       // 1
        logic             active;        // 0
    } ctl_t;

endpackage

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg
    import dbg_regbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          resuming_i,
    output ctl_t          ctl_o,
    output logic          ack_o
);

    typedef struct packed {
        ctl_t ctl;
        logic ack;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (resuming_i && st_q.ctl.resume_rq) begin
            st_d.ctl.resume_rq = 1'b0;
            st_d.ack           = 1'b1;
        end
        if (wr_en_i) begin
            if (wr_data_i[0]) begin
                st_d.ctl = ctl_t'(wr_data_i & CTL_MASK);
                if (wr_data_i[30]) st_d.ack = 1'b0;
            end else begin
                st_d.ctl = '0;
                st_d.ack = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl_o = st_q.ctl;
    assign ack_o = st_q.ack;

    // R3
    inactive_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_data_i[0]) |=> (ctl_o == '0 && !ack_o));

    // R6
    resume_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o.resume_rq && resuming_i && !wr_en_i) |=> (!ctl_o.resume_rq && ack_o));

endmodule

// File: rtl/dbg_status_build.sv
module dbg_status_build
    import dbg_regbank_pkg::*;
#(
    parameter logic [3:0] VERSION = 4'd2
) (
    input  logic          halted_i,
    input  logic          ack_i,
    output logic [DW-1:0] status_o
);

    always_comb begin
        status_o        = '0;
        status_o[17]    = ack_i;
        status_o[16]    = ack_i;
        status_o[11]    = ~halted_i;
        status_o[10]    = ~halted_i;
        status_o[9]     = halted_i;
        status_o[8]     = halted_i;
        status_o[7]     = 1'b1;
        status_o[3:0]   = VERSION;
    end

endmodule

// File: rtl/dbg_rsp_reg.sv
module dbg_rsp_reg
    import dbg_regbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [1:0]    req_op_i,
    input  logic [DW-1:0] req_data_i,
    input  logic [DW-1:0] ctl_word_i,
    input  logic [DW-1:0] status_word_i,
    input  logic          active_i,
    output logic          rsp_valid_o,
    output logic [DW-1:0] rsp_data_o,
    output logic          cmd_valid_o,
    output logic [DW-1:0] cmd_word_o
);

    typedef struct packed {
        logic          rsp_valid;
        logic [DW-1:0] rsp_data;
        logic          cmd_valid;
        logic [DW-1:0] cmd_word;
    } st_t;

    st_t st_d, st_q;
    logic is_rd, is_wr;

    always_comb begin
        is_rd = req_valid_i && (req_op_i == OP_READ);
        is_wr = req_valid_i && (req_op_i == OP_WRITE);
        st_d           = st_q;
        st_d.rsp_valid = is_rd || is_wr;
        st_d.rsp_data  = '0;
        st_d.cmd_valid = 1'b0;
        if (is_rd) begin
            if (req_addr_i == CTL_ADDR)      st_d.rsp_data = ctl_word_i;
            else if (req_addr_i == STS_ADDR) st_d.rsp_data = status_word_i;
        end
        if (is_wr && req_addr_i == CMD_ADDR && active_i) begin
            st_d.cmd_valid = 1'b1;
            st_d.cmd_word  = req_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid_o = st_q.rsp_valid;
    assign rsp_data_o  = st_q.rsp_data;
    assign cmd_valid_o = st_q.cmd_valid;
    assign cmd_word_o  = st_q.cmd_word;

    // R1
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && (req_op_i == OP_READ || req_op_i == OP_WRITE)) |=> rsp_valid_o);

    // R8
    cmd_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_op_i == OP_WRITE && req_addr_i == CMD_ADDR && !active_i)
        |=> !cmd_valid_o);

endmodule

// File: rtl/dbg_regbank.sv
module dbg_regbank
    import dbg_regbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dmi_req_valid_i,
    input  logic [6:0]    dmi_req_addr_i,
    input  logic [1:0]    dmi_req_op_i,
    input  logic [31:0]   dmi_req_data_i,
    output logic          dmi_rsp_valid_o,
    output logic [31:0]   dmi_rsp_data_o,
    input  logic          hart_halted_i,
    input  logic          hart_resuming_i,
    output logic          halt_req_o,
    output logic          resume_req_o,
    output logic          cmd_valid_o,
    output logic [31:0]   cmd_word_o
);

    ctl_t          ctl;
    logic          ack;
    logic          ctl_wr;
    logic          sel_ok;
    logic [DW-1:0] status_word;

    assign ctl_wr = dmi_req_valid_i && dmi_req_op_i == OP_WRITE && dmi_req_addr_i == CTL_ADDR;

    dbg_ctl_reg u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (ctl_wr),
        .wr_data_i  (dmi_req_data_i),
        .resuming_i (hart_resuming_i),
        .ctl_o      (ctl),
        .ack_o      (ack)
    );

    dbg_status_build u_sts (
        .halted_i (hart_halted_i),
        .ack_i    (ack),
        .status_o (status_word)
    );

    dbg_rsp_reg u_rsp (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid_i   (dmi_req_valid_i),
        .req_addr_i    (dmi_req_addr_i),
        .req_op_i      (dmi_req_op_i),
        .req_data_i    (dmi_req_data_i),
        .ctl_word_i    (DW'(ctl)),
        .status_word_i (status_word),
        .active_i      (ctl.active),
        .rsp_valid_o   (dmi_rsp_valid_o),
        .rsp_data_o    (dmi_rsp_data_o),
        .cmd_valid_o   (cmd_valid_o),
        .cmd_word_o    (cmd_word_o)
    );

    // single hart: only index 0 is served
    assign sel_ok       = (ctl.sel_hi == '0) && (ctl.sel_lo == '0);
    assign halt_req_o   = ctl.halt_rq   && sel_ok;
    assign resume_req_o = ctl.resume_rq && sel_ok;

    // R4
    halt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && dmi_req_data_i[0] && dmi_req_data_i[31] && dmi_req_data_i[25:6] == '0)
        |=> halt_req_o);

    // R5
    resume_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && dmi_req_data_i[0] && dmi_req_data_i[30] && dmi_req_data_i[25:6] == '0)
        |=> resume_req_o);

endmodule

// File: tb/dbg_regbank_tb.sv
module dbg_regbank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [1:0]  req_op = '0;
    logic [31:0] req_data = '0;
    logic        halted = 1'b0;
    logic        resuming = 1'b0;
    logic        rsp_valid, halt_req, resume_req, cmd_valid;
    logic [31:0] rsp_data, cmd_word;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    dbg_regbank dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .dmi_req_valid_i (req_valid),
        .dmi_req_addr_i  (req_addr),
        .dmi_req_op_i    (req_op),
        .dmi_req_data_i  (req_data),
        .dmi_rsp_valid_o (rsp_valid),
        .dmi_rsp_data_o  (rsp_data),
        .hart_halted_i   (halted),
        .hart_resuming_i (resuming),
        .halt_req_o      (halt_req),
        .resume_req_o    (resume_req),
        .cmd_valid_o     (cmd_valid),
        .cmd_word_o      (cmd_word)
    );

    // behavioural reference state
    bit [31:0] m_ctl;
    bit        m_ack;
    bit        m_rv;
    bit [31:0] m_rd;
    bit        m_cv;
    bit [31:0] m_cw;

    function automatic bit [31:0] m_status(bit h, bit a);
        return {14'd0, a, a, 4'd0, !h, !h, h, h, 1'b1, 3'd0, 4'd2};
    endfunction

    function automatic bit m_sel(bit [31:0] c);
        return c[25:6] == 20'd0;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctl = 0; m_ack = 0; m_rv = 0; m_rd = 0; m_cv = 0; m_cw = 0;
        end else begin
            bit rd, wr, wctl;
            bit [31:0] nctl;
            bit nack;
            rd   = req_valid && req_op == 2'd1;
            wr   = req_valid && req_op == 2'd2;
            wctl = wr && req_addr == 7'h10;
            m_rv = rd || wr;
            m_rd = 0;
            if (rd && req_addr == 7'h10) m_rd = m_ctl;
            if (rd && req_addr == 7'h11) m_rd = m_status(halted, m_ack);
            m_cv = wr && req_addr == 7'h17 && m_ctl[0];
            if (m_cv) m_cw = req_data;
            nctl = m_ctl;
            nack = m_ack;
            if (resuming && m_ctl[30]) begin nctl[30] = 0; nack = 1; end
            if (wctl) begin
                nctl = req_data[0] ? (req_data & 32'hF7FF_FFCF) : 32'd0;
                if (!req_data[0] || req_data[30]) nack = 0;
            end
            m_ctl = nctl;
            m_ack = nack;
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            check(halt_req == (m_ctl[31] && m_sel(m_ctl)), "R4 model halt_req", 32'(halt_req), 32'(m_ctl[31] && m_sel(m_ctl)));
            check(resume_req == (m_ctl[30] && m_sel(m_ctl)), "R5 model resume_req", 32'(resume_req), 32'(m_ctl[30] && m_sel(m_ctl)));
            check(rsp_valid == m_rv, "R1 model rsp_valid", 32'(rsp_valid), 32'(m_rv));
            if (m_rv) check(rsp_data == m_rd, "R1 model rsp_data", rsp_data, m_rd);
            check(cmd_valid == m_cv, "R8 model cmd_valid", 32'(cmd_valid), 32'(m_cv));
            if (m_cv) check(cmd_word == m_cw, "R8 model cmd_word", cmd_word, m_cw);
        end
    end

    task automatic req(logic [1:0] op, logic [6:0] a, logic [31:0] d);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'd0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        check(!halt_req && !resume_req && !rsp_valid && !cmd_valid, "R9 outputs low", {halt_req, resume_req, rsp_valid, cmd_valid}, 0);
        req(2'd1, 7'h10, 0);
        check(rsp_data == 0, "R9 ctl reads zero", rsp_data, 0);
        req(2'd1, 7'h11, 0);
        check(rsp_data == 32'h0000_0C82, "R7 status running", rsp_data, 32'h0000_0C82);
        // R4 halt
        req(2'd2, 7'h10, 32'h8000_0001);
        check(halt_req == 1'b1, "R4 halt set", 32'(halt_req), 1);
        check(rsp_valid && rsp_data == 0, "R1 write rsp zero", rsp_data, 0);
        idle();
        check(!rsp_valid, "R1 single cycle rsp", 32'(rsp_valid), 0);
        halted = 1'b1;
        req(2'd1, 7'h11, 0);
        check(rsp_data == 32'h0000_0382, "R7 status halted", rsp_data, 32'h0000_0382);
        // R2 field layout
        req(2'd2, 7'h10, 32'hFFFF_FFFF);
        req(2'd1, 7'h10, 0);
        check(rsp_data == 32'hF7FF_FFCF, "R2 reserved zero", rsp_data, 32'hF7FF_FFCF);
        check(!halt_req, "R4 unselected hart", 32'(halt_req), 0);
        // R5 resume
        halted = 1'b0;
        req(2'd2, 7'h10, 32'h4000_0001);
        check(resume_req && !halt_req, "R5 resume set", {halt_req, resume_req}, 1);
        resuming = 1'b1; idle(); resuming = 1'b0;
        check(!resume_req, "R6 resume cleared", 32'(resume_req), 0);
        req(2'd1, 7'h11, 0);
        check(rsp_data == 32'h0003_0C82, "R6 ack set", rsp_data, 32'h0003_0C82);
        req(2'd2, 7'h10, 32'h4000_0001);
        req(2'd1, 7'h11, 0);
        check(rsp_data == 32'h0000_0C82, "R6 ack cleared by write", rsp_data, 32'h0000_0C82);
        // R6 collision: write wins over same-cycle resuming
        resuming = 1'b1;
        req(2'd2, 7'h10, 32'h4000_0001);
        resuming = 1'b0;
        check(resume_req, "R6 write precedence", 32'(resume_req), 1);
        req(2'd1, 7'h11, 0);
        check(rsp_data == 32'h0000_0C82, "R6 no ack on collision", rsp_data, 32'h0000_0C82);
        // R3 deactivate
        req(2'd2, 7'h10, 32'h8000_0000);
        check(!halt_req && !resume_req, "R3 outputs low", {halt_req, resume_req}, 0);
        req(2'd1, 7'h10, 0);
        check(rsp_data == 0, "R3 ctl zero", rsp_data, 0);
        // R8 command trigger
        req(2'd2, 7'h17, 32'h0000_1234);
        check(!cmd_valid, "R8 inactive ignored", 32'(cmd_valid), 0);
        req(2'd2, 7'h10, 32'h0000_0001);
        req(2'd2, 7'h17, 32'h0000_1234);
        check(cmd_valid && cmd_word == 32'h1234, "R8 trigger", cmd_word, 32'h1234);
        idle();
        check(!cmd_valid, "R8 one cycle", 32'(cmd_valid), 0);
        // R1 other addresses and codes
        req(2'd1, 7'h12, 0);
        check(rsp_valid && rsp_data == 0, "R1 unmapped read", rsp_data, 0);
        req(2'd3, 7'h10, 0);
        check(!rsp_valid, "R1 code 3 ignored", 32'(rsp_valid), 0);
        req(2'd0, 7'h10, 0);
        check(!rsp_valid, "R1 code 0 ignored", 32'(rsp_valid), 0);
        repeat (3) idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<5000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule